// File: doc/BRIEF.md
# Sequential Add-Shift Unsigned Multiplier

This block multiplies two unsigned operands, 8 bits each by default, into a double-width product. It uses one ripple-carry adder and one product register, and spends one clock per partial-product addition and one clock per shift. A controller walks the multiplier from its lowest bit to its highest. A 1 bit costs an add cycle followed by a shift cycle. A 0 bit costs only the shift cycle. The adder's carry out is parked in its own flip-flop between the add and the following shift. The shift moves it into the product's top bit and then clears it.

The caller raises `start` and holds it, with both operands steady, until `done` has pulsed. The caller then lowers `start`. Dropping `start` at any moment returns the controller to idle on the next edge. While `start` stays high after completion, nothing restarts. The product stays on `product` until the load cycle of the next multiply. `start` and `done` are plain control pins with no back-pressure: the block accepts a job only from idle, and the result is simply held.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst` is sampled high, the controller goes idle, and after reset `product` reads 0 and `done` reads 0.
- R2: The cycle after the controller leaves idle is a load cycle. It captures both operands and clears the product register and the carry flip-flop, so `product` reads 0 after that edge whatever it held before.
- R3: Number the first rising edge that sees `start` high as edge 1. `done` is then high in the cycle after edge 10 + k, where k is the count of 1 bits in the multiplier: one idle exit, one load, k adds and 8 shifts. A multiplier of 0 gives 10 and 0xFF gives 18.
- R4: When `done` is high, `product` equals multiplicand × multiplier, both taken as unsigned.
- R5: A carry out of an add reaches the product top bit on the following shift. The carry flip-flop is then cleared, so a later 0 multiplier bit shifts in 0. Two results depend on this: 255 × 255 = 65025 and 255 × 0x81 = 32895.
- R6: `done` stays high for exactly one cycle. `product` stays unchanged from that cycle until the next load cycle, including after `start` is lowered.
- R7: A low `start` sampled at any edge sends the controller to idle. An aborted multiply never raises `done`, and the next full multiply is correct.
- R8: If `start` stays high after `done`, the block stays idle-complete: no new multiply begins, `done` stays low and `product` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Held high to run one multiply; low forces idle |
| mcand | input | 8 | Unsigned multiplicand, steady while start is high |
| mplier | input | 8 | Unsigned multiplier, steady while start is high |
| product | output | 16 | Unsigned product register |
| done | output | 1 | One-cycle completion pulse |

## Verification
The multiplicand 255 is paired with every multiplier, and every multiplicand is paired with 255. These sweeps make the adder overflow on most add cycles, so a lost carry or a carry not cleared after the shift shows up at once. The same sweeps vary the number of 1 bits in the multiplier from 0 to 8, so the latency check tells an add cycle skipped or inserted apart from a missing shift. A coarse grid of mixed operands covers sparse and alternating bit patterns. Directed cases cover an abort in the middle of a run, `start` held after completion, and a reload over a non-zero previous product.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam int unsigned MUL_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ADD,
    ST_SHIFT,
    ST_DONE,
    ST_HOLD
  } mul_state_t;
endpackage

// File: rtl/mul_rca.sv
module mul_rca #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;

  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & c[i]);
  end

  assign cout_o = c[W];
endmodule

// File: rtl/mul_accum.sv
module mul_accum #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_i,
  input  logic           add_i,
  input  logic           shift_i,
  input  logic [W-1:0]   mcand_i,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned PW = 2 * W;

  logic [W-1:0]  mcand_q;
  logic [PW-1:0] prod_q;
  logic          carry_q;
  logic [W-1:0]  sum;
  logic          cout;

  mul_rca #(.W(W)) u_rca (
    .a_i   (prod_q[PW-1:W]),
    .b_i   (mcand_q),
    .cin_i (1'b0),
    .sum_o (sum),
    .cout_o(cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      prod_q  <= '0;
      carry_q <= 1'b0;
    end else if (clr_i) begin
      mcand_q <= mcand_i;
      prod_q  <= '0;
      carry_q <= 1'b0;
    end else if (add_i) begin
      prod_q[PW-1:W] <= sum;
      carry_q        <= cout;
    end else if (shift_i) begin
      prod_q  <= {carry_q, prod_q[PW-1:1]};
      carry_q <= 1'b0;
    end
  end

  assign prod_o = prod_q;

  a_r2_load_clears: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (prod_q == '0) && !carry_q);

  a_r5_carry_cleared: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !clr_i && !add_i) |=> !carry_q);

  a_r5_carry_enters_msb: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !clr_i && !add_i) |=> prod_q[PW-1] == $past(carry_q));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !add_i && !shift_i) |=> $stable(prod_q));
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] mplier_i,
  output logic         clr_o,
  output logic         add_o,
  output logic         shift_o,
  output logic         done_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mul_state_t    state_q, state_d;
  logic [W-1:0]  bits_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    if (!start_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_LOAD;
        ST_LOAD:  state_d = mplier_i[0] ? ST_ADD : ST_SHIFT;
        ST_ADD:   state_d = ST_SHIFT;
        ST_SHIFT: begin
          if (cnt_q == LAST)  state_d = ST_DONE;
          else if (bits_q[1]) state_d = ST_ADD;
          else                state_d = ST_SHIFT;
        end
        ST_DONE:  state_d = ST_HOLD;
        ST_HOLD:  state_d = ST_HOLD;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_LOAD) begin
        bits_q <= mplier_i;
        cnt_q  <= '0;
      end else if (state_q == ST_SHIFT) begin
        bits_q <= bits_q >> 1;
        cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  assign clr_o   = (state_q == ST_LOAD);
  assign add_o   = (state_q == ST_ADD);
  assign shift_o = (state_q == ST_SHIFT);
  assign done_o  = (state_q == ST_DONE);

  a_r7_start_low_idle: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> state_q == ST_IDLE);

  a_r5_add_then_shift: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADD && start_i) |=> state_q == ST_SHIFT);

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r8_hold_stays: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && start_i) |=> (state_q == ST_HOLD) && !clr_o);

  a_r3_shift_bound: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SHIFT) |-> cnt_q <= LAST);

  a_r3_done_after_all_shifts: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> cnt_q == CW'(W));
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
  import mul_pkg::*;
#(
  parameter int unsigned W = MUL_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product,
  output logic           done
);
  logic clr, add, shift;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .mplier_i(mplier),
    .clr_o   (clr),
    .add_o   (add),
    .shift_o (shift),
    .done_o  (done)
  );

  mul_accum #(.W(W)) u_accum (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr),
    .add_i  (add),
    .shift_i(shift),
    .mcand_i(mcand),
    .prod_o (product)
  );

  a_r1_one_op: assert property (@(posedge clk) disable iff (rst)
    $countones({clr, add, shift, done}) <= 1);
endmodule

// File: tb/shift_add_mult_test.sv
`timescale 1ns/1ps
module shift_add_mult_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  mcand = '0;
  logic [7:0]  mplier = '0;
  logic [15:0] product;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  shift_add_mult uut (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .mcand  (mcand),
    .mplier (mplier),
    .product(product),
    .done   (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One full multiply; hold = extra cycles start stays high after done.
  task automatic run_mul(input logic [7:0] a, input logic [7:0] b,
                         input int hold, input string req);
    int lat = 0;
    bit seen = 0;
    bit held_ok = 1;
    int exp = int'(a) * int'(b);
    int k = $countones(b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    while (!seen && lat < 64) begin
      @(posedge clk); #1;
      lat++;
      if (done) seen = 1;
    end
    chk(seen && lat == 10 + k, "R3 latency", lat, 10 + k);
    chk(product == 16'(exp), req, int'(product), exp);
    @(posedge clk); #1;
    chk(!done && product == 16'(exp), "R6 one-cycle done, held product",
        int'(product), exp);
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); #1;
      if (done || product != 16'(exp)) held_ok = 0;
    end
    if (hold > 0) chk(held_ok, "R8 no restart while start held", int'(product), exp);
    @(negedge clk); start = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(!done && product == 16'(exp), "R6 product after start low", int'(product), exp);
  endtask

  task automatic t_reset;
    rst = 1'b1; start = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(product == 16'd0 && !done, "R1 reset state", int'(product), 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_corners;
    run_mul(8'd1, 8'd1, 0, "R4 1x1");
    run_mul(8'd0, 8'd0, 0, "R4 0x0 (R3 k=0)");
    run_mul(8'd255, 8'd255, 0, "R5 255x255=65025");
    run_mul(8'd255, 8'h81, 0, "R5 carry cleared before zero bits");
    run_mul(8'd255, 8'h01, 0, "R5 carry into top bit then zeros");
    run_mul(8'h80, 8'h80, 0, "R4 top bits only");
  endtask

  task automatic t_load_clears;
    run_mul(8'd255, 8'd255, 0, "R4 setup");
    @(negedge clk);
    mcand = 8'd9; mplier = 8'd2; start = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk(product == 16'd0, "R2 load clears product", int'(product), 0);
    @(negedge clk); start = 1'b0;
    @(posedge clk); #1;
    run_mul(8'd9, 8'd2, 0, "R2 result after reload");
  endtask

  task automatic t_abort;
    bit no_done = 1;
    @(negedge clk);
    mcand = 8'd255; mplier = 8'd255; start = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #1;
      if (done) no_done = 0;
    end
    chk(no_done, "R7 abort raises no done", int'(no_done), 1);
    run_mul(8'd200, 8'd123, 0, "R7 multiply after abort");
  endtask

  task automatic t_hold;
    run_mul(8'd37, 8'hA5, 40, "R8 result before hold");
  endtask

  task automatic t_sweeps;
    for (int b = 0; b < 256; b++) run_mul(8'd255, 8'(b), 0, "R5 255 x every multiplier");
    for (int a = 0; a < 256; a++) run_mul(8'(a), 8'd255, 0, "R5 every multiplicand x 255");
    for (int a = 0; a < 256; a += 17)
      for (int b = 0; b < 256; b += 13)
        run_mul(8'(a), 8'(b), 0, "R4 mixed grid");
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #750000;
    checks++; fails++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_load_clears();
    t_abort();
    t_hold();
    t_sweeps();
    summary();
    $finish;
  end
endmodule